// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits beside a small word-addressed memory and carries out read-modify-write operations on it as indivisible units. One requester drives an opcode, a word address and two register operands (`rx`, `ry`). The unit reads the addressed word, computes a new value from the opcode, writes it back if the opcode calls for a write, and returns a result word, an updated `ry` value and a one-cycle done pulse.

Work moves through three states. `ST_IDLE` waits for a request. An accepted request takes the transition IDLE→READ. `ST_READ` latches the old memory word and always moves READ→WRITE. `ST_WRITE` commits the write and the result, and always moves WRITE→IDLE. While the unit is in READ or WRITE, any request is refused with `req_nack` and has no effect. The requester must present it again later. No other access can therefore reach memory between the read and the write of an operation.

Opcode encoding on `req_op`: 0 load, 1 store, 2 test-and-set, 3 fetch-and-add, 4 fetch-and-subtract, 5 exchange, 6 compare-and-swap, 7 reserved. Increment and decrement are fetch-and-add and fetch-and-subtract with `rx` = 1.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads 0, and `rsp_done` and `req_nack` are 0.
- R2: A request accepted at clock edge T (`req_valid`=1 with the unit in `ST_IDLE`) gives a `rsp_done` pulse exactly one cycle wide, asserted after edge T+2. A new request may be accepted in the done cycle.
- R3: When `req_valid` is 1 in `ST_READ` or `ST_WRITE`, `req_nack` is 1, and the refused request changes neither memory nor any response.
- R4: Load (op 0) returns the word and does not change it. Store (op 1) writes `rx` and returns `rx`.
- R5: Test-and-set (op 2) returns the old word and writes 1. A return of 0 means the lock was obtained, and a return of 1 means it was already held.
- R6: Fetch-and-add (op 3) and fetch-and-subtract (op 4) return the old word and write old+`rx` or old−`rx`, modulo 2^DATA_W.
- R7: Exchange (op 5) writes `rx` and returns the old word.
- R8: Compare-and-swap (op 6) with word == `rx` writes `ry`, returns the old word and returns `rx` on `rsp_ry`.
- R9: Compare-and-swap with word != `rx` leaves memory unchanged, returns the current word and returns the `ry` operand unchanged on `rsp_ry`.
- R10: Opcode 7 behaves as a load: it returns the word and writes nothing.
- R11: For every opcode other than a matching compare-and-swap, `rsp_ry` equals the `ry` operand of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Opcode (see encoding above) |
| req_addr | input | ADDR_W | Word address |
| req_rx | input | DATA_W | Register operand Rx |
| req_ry | input | DATA_W | Register operand Ry |
| req_nack | output | 1 | Request refused because an operation is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_value | output | DATA_W | Result word, valid with `rsp_done` |
| rsp_ry | output | DATA_W | Updated Ry value, valid with `rsp_done` |

## Verification
The hardest situation to reach is a second request that arrives in the middle of an operation. That request must be refused without reaching memory, in the window between the read and the write. The stimulus first issues an exchange. In the next two cycles, while the unit is reading and then writing, it drives a store to a different address and samples `req_nack` in each cycle. It then withdraws the store and later loads that address to show that the word is still zero. Back-to-back requests are also issued in the done cycle, so that the refusal logic is also exercised at its closing edge.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_FADD  = 3'd3,
        OP_FSUB  = 3'd4,
        OP_XCHG  = 3'd5,
        OP_CAS   = 3'd6,
        OP_RSVD  = 3'd7
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } amo_state_e;

endpackage

// File: rtl/atomic_word_mem.sv
module atomic_word_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
    import atomic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  amo_op_e           op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] rx,
    input  logic [DATA_W-1:0] ry,
    output logic              we,
    output logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] ry_out
);

    localparam logic [DATA_W-1:0] LOCK_SET = DATA_W'(1);

    logic hit;
    assign hit = (old_val == rx);

    always_comb begin
        we      = 1'b0;
        new_val = old_val;
        result  = old_val;
        ry_out  = ry;
        unique case (op)
            OP_LOAD, OP_RSVD: begin
                we = 1'b0;
            end
            OP_STORE: begin
                we      = 1'b1;
                new_val = rx;
                result  = rx;
            end
            OP_TAS: begin
                we      = 1'b1;
                new_val = LOCK_SET;
            end
            OP_FADD: begin
                we      = 1'b1;
                new_val = old_val + rx;
            end
            OP_FSUB: begin
                we      = 1'b1;
                new_val = old_val - rx;
            end
            OP_XCHG: begin
                we      = 1'b1;
                new_val = rx;
            end
            OP_CAS: begin
                if (hit) begin
                    we      = 1'b1;
                    new_val = ry;
                    ry_out  = rx;
                end
            end
        endcase
    end

endmodule

// File: rtl/atomic_ctrl.sv
module atomic_ctrl
    import atomic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output amo_state_e state,
    output logic       accept,
    output logic       nack,
    output logic       latch_old,
    output logic       commit,
    output logic       done
);

    amo_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_WRITE);
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        accept    = 1'b0;
        nack      = 1'b0;
        latch_old = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    state_nx = ST_READ;
                end
            end
            ST_READ: begin
                nack      = req_valid;
                latch_old = 1'b1;
                state_nx  = ST_WRITE;
            end
            ST_WRITE: begin
                nack     = req_valid;
                commit   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    a_r2_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_READ));
    a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |=> (state == ST_WRITE));
    a_r2_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> (done && state == ST_IDLE));
    a_r2_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_rx,
    input  logic [DATA_W-1:0] req_ry,
    output logic              req_nack,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_value,
    output logic [DATA_W-1:0] rsp_ry
);

    amo_state_e        state;
    logic              accept, latch_old, commit;
    amo_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rx_q, ry_q, old_q;
    logic [DATA_W-1:0] mem_rdata, alu_new, alu_res, alu_ry;
    logic              alu_we, mem_we;

    atomic_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .state     (state),
        .accept    (accept),
        .nack      (req_nack),
        .latch_old (latch_old),
        .commit    (commit),
        .done      (rsp_done)
    );

    // operand capture on acceptance, old word capture in the read phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LOAD;
            addr_q <= '0;
            rx_q   <= '0;
            ry_q   <= '0;
            old_q  <= '0;
        end else begin
            if (accept) begin
                op_q   <= amo_op_e'(req_op);
                addr_q <= req_addr;
                rx_q   <= req_rx;
                ry_q   <= req_ry;
            end
            if (latch_old) begin
                old_q <= mem_rdata;
            end
        end
    end

    atomic_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op_q),
        .old_val (old_q),
        .rx      (rx_q),
        .ry      (ry_q),
        .we      (alu_we),
        .new_val (alu_new),
        .result  (alu_res),
        .ry_out  (alu_ry)
    );

    assign mem_we = commit & alu_we;

    atomic_word_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_q),
        .we    (mem_we),
        .wdata (alu_new),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_value <= '0;
            rsp_ry    <= '0;
        end else if (commit) begin
            rsp_value <= alu_res;
            rsp_ry    <= alu_ry;
        end
    end

    a_r3_refused_not_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nack) |=> ($stable(addr_q) && $stable(rx_q) && $stable(op_q)));
    a_r3_write_only_in_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_WRITE));
    a_r5_tas_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && op_q == OP_TAS) |-> (mem_we && alu_new == DATA_W'(1)));
    a_r9_cas_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && op_q == OP_CAS && old_q != rx_q) |-> !mem_we);
    a_r10_rsvd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && op_q == OP_RSVD) |-> !mem_we);

endmodule

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;

    localparam int  PERIOD = 10;
    localparam int  DW     = 32;
    localparam int  DEPTH  = 16;
    localparam int  AW     = $clog2(DEPTH);

    localparam logic [2:0] LD = 3'd0, ST = 3'd1, TAS = 3'd2, FADD = 3'd3,
                           FSUB = 3'd4, XCHG = 3'd5, CAS = 3'd6, RSV = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_rx = '0, req_ry = '0;
    logic          req_nack, rsp_done;
    logic [DW-1:0] rsp_value, rsp_ry;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [DW-1:0] val;
        logic [DW-1:0] ry;
        time           t_acc;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] model [DEPTH];

    always #(PERIOD/2) clk = ~clk;

    atomic_rmw_unit #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_rx(req_rx), .req_ry(req_ry),
        .req_nack(req_nack), .rsp_done(rsp_done),
        .rsp_value(rsp_value), .rsp_ry(rsp_ry)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: computes the expected response from the requirements and pushes it
    task automatic issue(input logic [2:0] op, input int addr, input logic [DW-1:0] rx,
                         input logic [DW-1:0] ry, input string tag);
        exp_t          e;
        logic [DW-1:0] old;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(addr);
        req_rx    = rx;
        req_ry    = ry;
        #1;
        while (req_nack) begin
            @(negedge clk);
            #1;
        end
        old   = model[addr];
        e.val = old;
        e.ry  = ry;
        e.tag = tag;
        case (op)
            ST:   begin model[addr] = rx; e.val = rx; end
            TAS:  model[addr] = 1;
            FADD: model[addr] = old + rx;
            FSUB: model[addr] = old - rx;
            XCHG: model[addr] = rx;
            CAS:  if (old == rx) begin model[addr] = ry; e.ry = rx; end
            default: ;
        endcase
        @(posedge clk);
        e.t_acc = $time;
        sb.push_back(e);
        #1;
        req_valid = 1'b0;
    endtask

    // monitor: pops and compares each completion
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_value == e.val, {e.tag, " value"}, rsp_value, e.val);
                check(rsp_ry == e.ry, {e.tag, " ry"}, rsp_ry, e.ry);
                check(($time - e.t_acc) == time'(2*PERIOD + PERIOD/2), "R2 latency",
                      DW'($time - e.t_acc), DW'(2*PERIOD + PERIOD/2));
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rsp_done == 1'b0, "R1 done after reset", DW'(rsp_done), 0);
        check(req_nack == 1'b0, "R1 nack after reset", DW'(req_nack), 0);
        issue(LD, 5, 0, 32'h77, "R1 load zero");
        issue(LD, 15, 0, 0, "R1 load top");

        // R4 load/store
        issue(ST, 3, 32'h55, 32'h11, "R4 store");
        issue(LD, 3, 0, 0, "R4 load back");
        issue(ST, 15, 32'hFFFF_0001, 0, "R4 store top");
        issue(LD, 15, 0, 0, "R4 load top");

        // R5 test-and-set
        issue(TAS, 7, 0, 0, "R5 tas free");
        issue(TAS, 7, 0, 0, "R5 tas held");
        issue(LD, 7, 0, 0, "R5 lock word");

        // R6 fetch-and-op with wrap
        issue(FADD, 3, 1, 0, "R6 increment");
        issue(FSUB, 3, 32'h60, 0, "R6 subtract");
        issue(LD, 3, 0, 0, "R6 wrapped");
        issue(FADD, 3, 32'h20, 0, "R6 add wrap");
        issue(LD, 3, 0, 0, "R6 result");

        // R7 exchange, also probes refusal while busy (R3)
        issue(XCHG, 2, 32'hABCD, 32'h5, "R7 xchg");
        @(negedge clk);
        req_valid = 1'b1; req_op = ST; req_addr = AW'(9); req_rx = 32'hDEAD;
        #1;
        check(req_nack == 1'b1, "R3 nack in read phase", DW'(req_nack), 1);
        @(negedge clk);
        #1;
        check(req_nack == 1'b1, "R3 nack in write phase", DW'(req_nack), 1);
        req_valid = 1'b0;
        issue(LD, 2, 0, 0, "R7 load back");
        issue(LD, 9, 0, 0, "R3 refused store absent");

        // R8 / R9 compare-and-swap
        issue(CAS, 2, 32'hABCD, 32'h1234, "R8 cas hit");
        issue(LD, 2, 0, 0, "R8 word swapped");
        issue(CAS, 2, 32'h0, 32'h9, "R9 cas miss");
        issue(LD, 2, 0, 0, "R9 word kept");

        // R10 reserved opcode, R11 ry passthrough
        issue(RSV, 2, 32'h4444, 32'h3, "R10 reserved op");
        issue(LD, 2, 0, 0, "R10 word kept");
        issue(XCHG, 4, 32'h8, 32'hCAFE, "R11 ry passthrough");

        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R2 all responses seen", DW'(sb.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule